// File: doc/BRIEF.md
# Recently accessed line tracker

A small fully associative table sitting beside a cache built from storage cells that leak their charge within a fixed retention window. Any read or write of a line restores its cells, so a line touched within the window cannot have lost bits to leakage. The table remembers which lines were touched recently. For those lines a single parity bit per 64-byte sub-block is enough to vouch for the data, and the expensive multi-bit correction path is needed only when that parity disagrees.

Time is split into four rotating periods, each a quarter of the retention window, advanced by an external tick. Every entry carries the number of the period in which it was last touched. When the period counter moves to a new value, entries tagged with that value have aged a full window and are dropped. A lookup resolves in one cycle: the access is matched against all entries, the hit entry is refreshed or a victim is replaced, and the outcome is registered for the next cycle.

Top module: `recent_line_tracker`

## Requirements
- R1: After reset the result outputs are low, the period counter is 0 and no entry is valid, so the first access of any line is a miss.
- R2: An access presented on a cycle without a tick produces res_valid high on the following cycle, with res_hit and res_mismatch for that access.
- R3: An access hits when a valid entry holds the same line address; on a miss the line is entered so that a following access to it hits.
- R4: A write hit stores the access parity in the bit selected by acc_sub (bit index equals the sub-block number) and leaves the other fifteen bits unchanged; a write never raises res_mismatch.
- R5: A read hit raises res_mismatch exactly when the stored bit for acc_sub differs from acc_parity; a miss never raises it.
- R6: A newly entered line gets a parity vector with acc_parity in the addressed bit and 0 in every other bit.
- R7: Each tick adds 1 modulo 4 to the period counter and drops every valid entry whose tag equals the new counter value, so a line not touched for four ticks misses.
- R8: A hit rewrites the entry's tag with the current period, so a line touched at least once every three ticks keeps hitting.
- R9: On a miss the replaced entry is the lowest-index invalid one; when all are valid it is the one with the largest age (current period minus tag, modulo 4), lowest index first among equals.
- R10: A tick and an access in the same cycle: the tick is served, the access is discarded, res_valid stays low next cycle and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_tick | input | 1 | One-cycle pulse each quarter of the retention window |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Line address |
| acc_sub | input | log2(SUBS) | Sub-block index within the line |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_parity | input | 1 | Parity of the accessed sub-block data |
| res_valid | output | 1 | Result of the previous cycle's access is present |
| res_hit | output | 1 | The line was in the table |
| res_mismatch | output | 1 | Read hit with differing parity; request full correction |

## Verification
The period sweep and a lookup can land on the same cycle, and the outcome then depends on which wins: the tick must be served and the access thrown away. The bench raises the tick together with accesses to both absent and present lines, then checks that no result appears, that an absent line still misses afterwards and that a discarded write has left the stored parity untouched. A long pseudo-random stream with a four-entry table also mixes ticks, coincident ticks and accesses, so ageing, purging and replacement interleave and every result is compared with an arithmetic model.

// File: rtl/rlt_pkg.sv
// Shared types and helpers for the recently accessed line tracker.
// Assumes four rotating periods, so a period number is two bits wide.
package rlt_pkg;
    typedef logic [1:0] period_t;

    // Age of a tag relative to the current period, modulo 4.
    function automatic period_t period_age(input period_t cur, input period_t tag);
        return period_t'(cur - tag);
    endfunction
endpackage

// File: rtl/rlt_match.sv
// Parallel address comparator: one compare per entry.
// Assumes at most one valid entry holds any address, so the result is one-hot or zero.
module rlt_match #(
    parameter int ENTRIES = 32,
    parameter int ADDR_W  = 20
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ADDR_W-1:0]  addr_tab [ENTRIES],
    input  logic [ADDR_W-1:0]  probe,
    output logic [ENTRIES-1:0] hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // One comparator per table slot.
        assign hit_vec[g] = valid_vec[g] && (addr_tab[g] == probe);
    end
endmodule

// File: rtl/rlt_victim.sv
// Replacement picker: lowest-index free slot, else the oldest tag,
// lowest index among equally old. Assumes tags are relative to cur.
module rlt_victim
    import rlt_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  period_t            tag_tab [ENTRIES],
    input  period_t            cur,
    output logic [IDX_W-1:0]   victim
);
    // Scan from the top so the lowest index wins every tie.
    always_comb begin
        logic    found_free;
        period_t best_age;
        found_free = 1'b0;
        best_age   = '0;
        victim     = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                found_free = 1'b1;
                victim     = IDX_W'(i);
            end
        end
        if (!found_free) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (i == 0 || period_age(cur, tag_tab[i]) > best_age) begin
                    best_age = period_age(cur, tag_tab[i]);
                    victim   = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/recent_line_tracker.sv
// Recently accessed line tracker. Fully associative table of lines touched
// within the retention window, aged by four rotating periods, with one
// parity bit per sub-block. One-cycle registered lookup result.
// Assumes period_tick is a single-cycle pulse; a tick wins over an access.
module recent_line_tracker
    import rlt_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int ADDR_W  = 20,
    parameter int SUBS    = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int SUB_W  = (SUBS > 1) ? $clog2(SUBS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_tick,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SUB_W-1:0]  acc_sub,
    input  logic              acc_write,
    input  logic              acc_parity,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_mismatch
);
    logic [ENTRIES-1:0] valid_q;
    logic [ADDR_W-1:0]  addr_q [ENTRIES];
    period_t            tag_q  [ENTRIES];
    logic [SUBS-1:0]    par_q  [ENTRIES];
    period_t            cur_period;
    period_t            next_period;

    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic               any_hit;
    logic [IDX_W-1:0]   victim;
    logic [SUBS-1:0]    fill_vec;

    rlt_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .valid_vec (valid_q),
        .addr_tab  (addr_q),
        .probe     (acc_addr),
        .hit_vec   (hit_vec)
    );

    rlt_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_vec (valid_q),
        .tag_tab   (tag_q),
        .cur       (cur_period),
        .victim    (victim)
    );

    // Encode the one-hot hit vector into an index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    // Hit summary, next period value and the parity vector for a fresh entry.
    always_comb begin
        any_hit     = |hit_vec;
        next_period = period_t'(cur_period + 2'd1);
        fill_vec    = '0;
        fill_vec[acc_sub] = acc_parity;
    end

    // Table state, period counter and registered lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q      <= '0;
            cur_period   <= '0;
            res_valid    <= 1'b0;
            res_hit      <= 1'b0;
            res_mismatch <= 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
                addr_q[i] <= '0;
                tag_q[i]  <= '0;
                par_q[i]  <= '0;
            end
        end else begin
            res_valid    <= 1'b0;
            res_hit      <= 1'b0;
            res_mismatch <= 1'b0;
            if (period_tick) begin
                cur_period <= next_period;
                for (int i = 0; i < ENTRIES; i++) begin
                    if (valid_q[i] && tag_q[i] == next_period) valid_q[i] <= 1'b0;
                end
            end else if (acc_valid) begin
                res_valid <= 1'b1;
                if (any_hit) begin
                    res_hit        <= 1'b1;
                    tag_q[hit_idx] <= cur_period;
                    if (acc_write) begin
                        par_q[hit_idx][acc_sub] <= acc_parity;
                    end else begin
                        res_mismatch <= par_q[hit_idx][acc_sub] != acc_parity;
                    end
                end else begin
                    valid_q[victim] <= 1'b1;
                    addr_q[victim]  <= acc_addr;
                    tag_q[victim]   <= cur_period;
                    par_q[victim]   <= fill_vec;
                end
            end
        end
    end
endmodule

// File: rtl/rlt_checker.sv
// Protocol and state checks for recent_line_tracker, bound into every instance.
// Assumes synchronous active-low reset; all properties are disabled during it.
module rlt_checker #(
    parameter int ENTRIES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               period_tick,
    input logic               acc_valid,
    input logic               acc_write,
    input logic               res_valid,
    input logic               res_hit,
    input logic               res_mismatch,
    input logic [1:0]         cur_period,
    input logic [ENTRIES-1:0] hit_vec
);
    assert_hit_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !period_tick |=> res_valid);

    assert_write_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && !period_tick |=> !res_mismatch);

    assert_flag_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_mismatch |-> res_valid && res_hit);

    assert_period_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick |=> cur_period == 2'($past(cur_period) + 2'd1));

    assert_period_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !period_tick |=> $stable(cur_period));

    assert_tick_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick |=> !res_valid);
endmodule

bind recent_line_tracker rlt_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_tick  (period_tick),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .res_valid    (res_valid),
    .res_hit      (res_hit),
    .res_mismatch (res_mismatch),
    .cur_period   (cur_period),
    .hit_vec      (hit_vec)
);

// File: tb/recent_line_tracker_tb.sv
// Bench: four-entry table, arithmetic model of tags, parity and replacement.
module recent_line_tracker_tb;
    localparam int N  = 4;
    localparam int AW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       period_tick = 1'b0;
    logic       acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [3:0] acc_sub = '0;
    logic       acc_write = 1'b0;
    logic       acc_parity = 1'b0;
    logic       res_valid, res_hit, res_mismatch;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic          mvalid [N];
    logic [AW-1:0] maddr  [N];
    logic [1:0]    mtag   [N];
    logic [15:0]   mpar   [N];
    logic [1:0]    mcur;

    recent_line_tracker #(.ENTRIES(N), .ADDR_W(AW), .SUBS(16)) u_dut (
        .clk, .rst_n, .period_tick, .acc_valid, .acc_addr, .acc_sub,
        .acc_write, .acc_parity, .res_valid, .res_hit, .res_mismatch
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; period_tick = 1'b0; acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            mvalid[i] = 1'b0; maddr[i] = '0; mtag[i] = '0; mpar[i] = '0;
        end
        mcur = 2'd0;
    endtask

    function automatic int model_victim();
        int v = -1;
        logic [1:0] best = '0;
        for (int i = N - 1; i >= 0; i--) if (!mvalid[i]) v = i;
        if (v >= 0) return v;
        for (int i = 0; i < N; i++) begin
            if (i == 0 || 2'(mcur - mtag[i]) > best) begin
                best = 2'(mcur - mtag[i]);
                v = i;
            end
        end
        return v;
    endfunction

    function automatic void model_tick();
        mcur = 2'(mcur + 2'd1);
        for (int i = 0; i < N; i++) if (mvalid[i] && mtag[i] == mcur) mvalid[i] = 1'b0;
    endfunction

    task automatic do_access(input logic [AW-1:0] a, input logic [3:0] s,
                             input logic w, input logic p, input string req);
        int h = -1;
        logic eh, em;
        for (int i = 0; i < N; i++) if (mvalid[i] && maddr[i] == a) h = i;
        eh = (h >= 0);
        em = eh && !w && (mpar[h][s] != p);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_sub = s; acc_write = w; acc_parity = p;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R2", "res_valid", res_valid, 1'b1);
        chk(req, "res_hit", res_hit, eh);
        chk(w ? "R4" : "R5", "res_mismatch", res_mismatch, em);
        if (eh) begin
            mtag[h] = mcur;
            if (w) mpar[h][s] = p;
        end else begin
            h = model_victim();
            mvalid[h] = 1'b1; maddr[h] = a; mtag[h] = mcur;
            mpar[h] = '0; mpar[h][s] = p;
        end
    endtask

    task automatic do_tick(input logic with_acc, input logic [AW-1:0] a,
                           input logic w, input logic p);
        @(negedge clk);
        period_tick = 1'b1;
        acc_valid = with_acc; acc_addr = a; acc_sub = 4'd0; acc_write = w; acc_parity = p;
        @(negedge clk);
        period_tick = 1'b0; acc_valid = 1'b0;
        chk("R10", "res_valid after tick", res_valid, 1'b0);
        model_tick();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        do_reset();
        // R1: quiet outputs and an empty table after reset.
        @(negedge clk);
        chk("R1", "res_valid", res_valid, 1'b0);
        chk("R1", "res_hit", res_hit, 1'b0);
        do_access(8'd1, 4'd0, 1'b0, 1'b0, "R1");
        do_access(8'd1, 4'd0, 1'b0, 1'b0, "R3");

        // R6: a write miss fills one bit; read every sub-block with parity 0.
        do_access(8'd10, 4'd3, 1'b1, 1'b1, "R3");
        for (int s = 0; s < 16; s++) do_access(8'd10, 4'(s), 1'b0, 1'b0, "R6");
        // R4 and R5: write each sub-block, then read with both parities.
        for (int s = 0; s < 16; s++) do_access(8'd10, 4'(s), 1'b1, 1'(s ^ (s >> 2)), "R4");
        for (int s = 0; s < 16; s++) begin
            do_access(8'd10, 4'(s), 1'b0, 1'b0, "R5");
            do_access(8'd10, 4'(s), 1'b0, 1'b1, "R5");
        end

        // R9: ties broken by lowest index, then oldest-first replacement.
        do_reset();
        for (int a = 1; a <= 4; a++) do_access(8'(a), 4'd0, 1'b0, 1'b0, "R9");
        do_access(8'd5, 4'd0, 1'b0, 1'b0, "R9");
        do_access(8'd2, 4'd0, 1'b0, 1'b0, "R9");
        do_access(8'd1, 4'd0, 1'b0, 1'b0, "R9");
        do_reset();
        do_access(8'd20, 4'd0, 1'b0, 1'b0, "R9");
        do_tick(1'b0, '0, 1'b0, 1'b0);
        do_access(8'd21, 4'd0, 1'b0, 1'b0, "R9");
        do_tick(1'b0, '0, 1'b0, 1'b0);
        do_access(8'd22, 4'd0, 1'b0, 1'b0, "R9");
        do_access(8'd23, 4'd0, 1'b0, 1'b0, "R9");
        do_access(8'd24, 4'd0, 1'b0, 1'b0, "R9");
        do_access(8'd20, 4'd0, 1'b0, 1'b0, "R9");
        do_access(8'd21, 4'd0, 1'b0, 1'b0, "R9");

        // R7: an untouched line expires after four ticks.
        do_reset();
        do_access(8'd30, 4'd0, 1'b0, 1'b0, "R7");
        repeat (3) do_tick(1'b0, '0, 1'b0, 1'b0);
        do_access(8'd31, 4'd0, 1'b0, 1'b0, "R7");
        do_tick(1'b0, '0, 1'b0, 1'b0);
        do_access(8'd30, 4'd0, 1'b0, 1'b0, "R7");
        do_access(8'd31, 4'd0, 1'b0, 1'b0, "R7");

        // R8: a hit refreshes the tag so the line outlives its first window.
        do_reset();
        do_access(8'd40, 4'd0, 1'b0, 1'b0, "R8");
        repeat (3) do_tick(1'b0, '0, 1'b0, 1'b0);
        do_access(8'd40, 4'd0, 1'b0, 1'b0, "R8");
        repeat (3) do_tick(1'b0, '0, 1'b0, 1'b0);
        do_access(8'd40, 4'd0, 1'b0, 1'b0, "R8");

        // R10: coincident tick and access; the access leaves no trace.
        do_reset();
        do_tick(1'b1, 8'd50, 1'b0, 1'b0);
        do_access(8'd50, 4'd0, 1'b0, 1'b0, "R10");
        do_access(8'd50, 4'd0, 1'b1, 1'b0, "R10");
        do_tick(1'b1, 8'd50, 1'b1, 1'b1);
        do_access(8'd50, 4'd0, 1'b0, 1'b0, "R10");

        // Mixed stream: accesses, ticks and coincident ticks.
        do_reset();
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'd0)
                do_tick(1'b0, '0, 1'b0, 1'b0);
            else if (lfsr[4:0] == 5'd1)
                do_tick(1'b1, 8'(lfsr[7:5]), lfsr[8], lfsr[9]);
            else
                do_access(8'(lfsr[7:5] % 6), lfsr[12:9], lfsr[13], lfsr[14], "R3");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule